// File: doc/BRIEF.md
# Five-Level Bridge Gate Sequencer

This block drives the six switches of a single-phase five-level bridge. The bridge is a full bridge with four switches, T1 to T4, plus two switches, T5 and T6, that tie its rails to the DC-link midpoint. Each cycle the block takes a signed reference sample and a PWM pulse from an external carrier comparator, and it produces the six gate commands.

The reference sample is examined only when the carrier-boundary strobe is high. Its sign picks the half-cycle. Its magnitude, compared against half of full scale, picks a low or a high zone. That gives four zones. Within the latched zone the PWM pulse selects the active phase (pulse high) or the freewheeling phase (pulse low), and each zone and phase has a fixed switch pattern. A switch that has to turn on is held low until a programmable dead time has passed since the last switch turned off. A switch that has to turn off is released on the next edge.

Top module: `h5_gate_seq`

## Requirements
- R1: While `rst_ni` is low, all six gates are low. After any rising edge at which `en_i` is low, all six gates are low.
- R2: At a rising edge with `carrier_sync_i` high, the zone is set from `ref_i`, read in two's complement. Sign bit clear selects positive, sign bit set selects negative. A magnitude of at least 2^(REF_W-2) selects high, a smaller one selects low. The boundaries are 1023 for positive low, 1024 for positive high, and -1024 for negative high.
- R3: `gate_o[i]` drives switch T(i+1). In the positive-low zone the active pattern is T1, T4, T6 and the freewheeling pattern is T1, T4. No pattern drives more than three gates.
- R4: In the positive-high zone the active pattern is T1, T4, T5 and the freewheeling pattern is T4, T5.
- R5: In the negative-low zone the active pattern is T2, T3, T6 and the freewheeling pattern is T2, T3.
- R6: In the negative-high zone the active pattern is T2, T3, T5 and the freewheeling pattern is T2, T5.
- R7: The zone changes only at a carrier strobe. A new `ref_i` without the strobe has no effect on the gates. A zone latched at edge k first shapes the gates at edge k+1.
- R8: A gate that leaves the target pattern falls at the next rising edge.
- R9: Let D be `dead_i` and D>0. A gate that enters the target pattern rises no earlier than D cycles after the most recent gate turn-off, and no gate falls at the edge where another gate rises. With D=0, turn-off and turn-on happen at the same edge.
- R10: A reference of zero maps to positive low. The most negative reference maps to negative high.
- R11: T1 and T2 are never on together, and T3 and T4 are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable. When low, all gates are forced off |
| carrier_sync_i | input | 1 | Carrier-boundary strobe that latches the zone |
| pwm_i | input | 1 | PWM pulse: 1 selects the active phase, 0 the freewheeling phase |
| ref_i | input | REF_W | Signed reference sample |
| dead_i | input | DT_W | Dead time, in clock cycles |
| gate_o | output | 6 | Gate commands; bit i drives T(i+1) |

## Verification
The gates are registered, so a change in `pwm_i` or `en_i` reaches `gate_o` one edge after it is applied. A strobed zone change reaches `gate_o` one edge later still. A turn-on that has to wait for the dead time lands D edges after the turn-off that started the wait. The driver applies inputs on the falling edge and, for that same cycle, pushes the gate word the requirements predict for the following rising edge. The monitor pops one entry per cycle and compares it 2 ns after that edge, so every comparison lines up with exactly one edge.

// File: rtl/h5_gate_pkg.sv
package h5_gate_pkg;
  localparam int unsigned NUM_GATES = 6;

  // {negative, high}
  typedef enum logic [1:0] {
    ZN_POS_LO = 2'd0,
    ZN_POS_HI = 2'd1,
    ZN_NEG_LO = 2'd2,
    ZN_NEG_HI = 2'd3
  } zone_e;

  localparam int unsigned G_T1 = 0;
  localparam int unsigned G_T2 = 1;
  localparam int unsigned G_T3 = 2;
  localparam int unsigned G_T4 = 3;
  localparam int unsigned G_T5 = 4;
  localparam int unsigned G_T6 = 5;
endpackage

// File: rtl/h5_zone_sel.sv
module h5_zone_sel
  import h5_gate_pkg::*;
#(
  parameter int unsigned REF_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic [REF_W-1:0] ref_i,
  output zone_e            zone_o
);
  localparam logic [REF_W-1:0] HALF_FS = {2'b01, {(REF_W-2){1'b0}}};

  logic             neg;
  logic             high;
  logic [REF_W-1:0] mag;
  zone_e            zone_d, zone_q;

  always_comb begin
    neg    = ref_i[REF_W-1];
    mag    = neg ? (~ref_i + {{(REF_W-1){1'b0}}, 1'b1}) : ref_i;
    high   = (mag >= HALF_FS);
    zone_d = zone_e'({neg, high});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     zone_q <= ZN_POS_LO;
    else if (sync_i) zone_q <= zone_d;
  end

  assign zone_o = zone_q;
endmodule

// File: rtl/h5_pattern.sv
module h5_pattern
  import h5_gate_pkg::*;
(
  input  zone_e                  zone_i,
  input  logic                   act_i,
  output logic [NUM_GATES-1:0]   tgt_o
);
  logic [NUM_GATES-1:0] base;
  logic [NUM_GATES-1:0] pulsed;

  // base: on for the whole phase; pulsed: on only in the active phase
  always_comb begin
    base   = '0;
    pulsed = '0;
    unique case (zone_i)
      ZN_POS_LO: begin
        base[G_T1] = 1'b1; base[G_T4] = 1'b1; pulsed[G_T6] = 1'b1;
      end
      ZN_POS_HI: begin
        base[G_T4] = 1'b1; base[G_T5] = 1'b1; pulsed[G_T1] = 1'b1;
      end
      ZN_NEG_LO: begin
        base[G_T2] = 1'b1; base[G_T3] = 1'b1; pulsed[G_T6] = 1'b1;
      end
      ZN_NEG_HI: begin
        base[G_T2] = 1'b1; base[G_T5] = 1'b1; pulsed[G_T3] = 1'b1;
      end
      default: ;
    endcase
    tgt_o = base | (act_i ? pulsed : '0);
  end
endmodule

// File: rtl/h5_dead_band.sv
module h5_dead_band #(
  parameter int unsigned NG   = 6,
  parameter int unsigned DT_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NG-1:0]   tgt_i,
  input  logic [DT_W-1:0] dead_i,
  output logic [NG-1:0]   gate_o
);
  localparam logic [DT_W-1:0] CNT_MAX = '1;
  localparam logic [DT_W-1:0] CNT_ONE = {{(DT_W-1){1'b0}}, 1'b1};

  logic [NG-1:0]   gate_q;
  logic [NG-1:0]   off_pend;
  logic [NG-1:0]   on_pend;
  logic [DT_W-1:0] since_off_q;  // cycles since last turn-off, saturating

  assign off_pend = gate_q & ~tgt_i;
  assign on_pend  = tgt_i & ~gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q      <= '0;
      since_off_q <= CNT_MAX;
    end else if (|off_pend) begin
      gate_q      <= (dead_i == '0) ? tgt_i : (gate_q & tgt_i);
      since_off_q <= CNT_ONE;
    end else begin
      if (|on_pend && since_off_q >= dead_i) gate_q <= tgt_i;
      if (since_off_q != CNT_MAX) since_off_q <= since_off_q + CNT_ONE;
    end
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/h5_gate_seq.sv
module h5_gate_seq
  import h5_gate_pkg::*;
#(
  parameter int unsigned REF_W = 12,
  parameter int unsigned DT_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             carrier_sync_i,
  input  logic             pwm_i,
  input  logic [REF_W-1:0] ref_i,
  input  logic [DT_W-1:0]  dead_i,
  output logic [5:0]       gate_o
);
  zone_e                zone_q;
  logic [NUM_GATES-1:0] tgt;
  logic [NUM_GATES-1:0] tgt_eff;

  h5_zone_sel #(.REF_W(REF_W)) u_zone (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (carrier_sync_i),
    .ref_i  (ref_i),
    .zone_o (zone_q)
  );

  h5_pattern u_pat (
    .zone_i (zone_q),
    .act_i  (pwm_i),
    .tgt_o  (tgt)
  );

  assign tgt_eff = en_i ? tgt : '0;

  h5_dead_band #(.NG(NUM_GATES), .DT_W(DT_W)) u_db (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tgt_i  (tgt_eff),
    .dead_i (dead_i),
    .gate_o (gate_o)
  );
endmodule

// File: rtl/h5_gate_seq_chk.sv
module h5_gate_seq_chk
  import h5_gate_pkg::*;
#(
  parameter int unsigned DT_W = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            en_i,
  input logic            carrier_sync_i,
  input logic [DT_W-1:0] dead_i,
  input logic [5:0]      gate_o,
  input zone_e           zone_i
);
  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> gate_o == 6'b0); // R1

  AST_GATE_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gate_o) <= 3); // R3

  AST_ZONE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !carrier_sync_i |=> $stable(zone_i)); // R7

  AST_DEAD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dead_i != '0 && $stable(dead_i) && |(gate_o & ~$past(gate_o)))
      |-> ~|($past(gate_o) & ~gate_o)); // R9

  AST_NO_SHOOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_o[G_T1] && gate_o[G_T2]) && !(gate_o[G_T3] && gate_o[G_T4])); // R11
endmodule

bind h5_gate_seq h5_gate_seq_chk #(.DT_W(DT_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .en_i           (en_i),
  .carrier_sync_i (carrier_sync_i),
  .dead_i         (dead_i),
  .gate_o         (gate_o),
  .zone_i         (zone_q)
);

// File: tb/tb_h5_gate_seq.sv
`timescale 1ns/1ps
module tb_h5_gate_seq;
  localparam int unsigned REF_W = 12;
  localparam int unsigned DT_W  = 4;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              en_i = 1'b0;
  logic              carrier_sync_i = 1'b0;
  logic              pwm_i = 1'b0;
  logic [REF_W-1:0]  ref_i = '0;
  logic [DT_W-1:0]   dead_i = '0;
  logic [5:0]        gate_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [5:0] exp_q[$];
  string      tag_q[$];

  // bench model state
  logic [1:0] mz = 2'd0;
  logic [5:0] mg = '0;
  int         msince = 1000;

  h5_gate_seq #(.REF_W(REF_W), .DT_W(DT_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .carrier_sync_i(carrier_sync_i),
    .pwm_i(pwm_i), .ref_i(ref_i), .dead_i(dead_i), .gate_o(gate_o)
  );

  always #5 clk = ~clk;

  // bit0=T1 .. bit5=T6
  function automatic logic [5:0] pat(input logic [1:0] z, input logic p);
    case (z)
      2'd0:    return 6'b001001 | (p ? 6'b100000 : 6'b0);
      2'd1:    return 6'b011000 | (p ? 6'b000001 : 6'b0);
      2'd2:    return 6'b000110 | (p ? 6'b100000 : 6'b0);
      default: return 6'b010010 | (p ? 6'b000100 : 6'b0);
    endcase
  endfunction

  function automatic logic [1:0] zone_of(input int r);
    int mag;
    mag = (r < 0) ? -r : r;
    return {(r < 0) ? 1'b1 : 1'b0, (mag >= 1024) ? 1'b1 : 1'b0};
  endfunction

  task automatic step(input bit en, input int r, input bit p, input bit s,
                      input int d, input string tag);
    logic [5:0] tgt, offm, onm;
    @(negedge clk);
    en_i = en; ref_i = REF_W'(r); pwm_i = p; carrier_sync_i = s; dead_i = DT_W'(d);
    tgt  = en ? pat(mz, p) : 6'b0;
    offm = mg & ~tgt;
    onm  = tgt & ~mg;
    if (offm != 0) begin
      mg = (d == 0) ? tgt : (mg & tgt);
      msince = 1;
    end else begin
      if (onm != 0 && msince >= d) mg = tgt;
      msince++;
    end
    if (s) mz = zone_of(r);
    exp_q.push_back(mg);
    tag_q.push_back(tag);
  endtask

  task automatic hold(input int n, input bit en, input int r, input bit p,
                      input int d, input string tag);
    for (int i = 0; i < n; i++) step(en, r, p, 1'b0, d, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [5:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if (gate_o !== e) begin
          bad++;
          $display("FAIL %s gate_o=%b expected=%b at %0t", t, gate_o, e, $time);
        end
        total++;
        if ((gate_o[0] && gate_o[1]) || (gate_o[2] && gate_o[3])) begin
          bad++;
          $display("FAIL R11 gate_o=%b expected=no leg overlap", gate_o);
        end
      end
    end
  end

  // watchdog
  initial begin
    #2000000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (gate_o !== 6'b0) begin
      bad++;
      $display("FAIL R1 gate_o=%b expected=000000 in reset", gate_o);
    end
    rst_ni = 1'b1;

    // dead time 0: pattern coverage
    step(1, 0, 0, 1, 0, "R10");
    hold(2, 1, 0, 0, 0, "R3");
    hold(2, 1, 0, 1, 0, "R3");
    hold(1, 1, 0, 0, 0, "R3");
    step(1, 1500, 0, 1, 0, "R2");
    hold(2, 1, 1500, 1, 0, "R4");
    hold(2, 1, 1500, 0, 0, "R4");
    hold(3, 1, -500, 1, 0, "R7");
    step(1, -500, 0, 1, 0, "R7");
    hold(2, 1, -500, 0, 0, "R5");
    hold(2, 1, -500, 1, 0, "R5");
    step(1, -1024, 0, 1, 0, "R2");
    hold(2, 1, -1024, 1, 0, "R6");
    hold(2, 1, -1024, 0, 0, "R6");
    step(1, 1023, 0, 1, 0, "R2");
    hold(2, 1, 1023, 1, 0, "R3");
    step(1, 1024, 1, 1, 0, "R2");
    hold(2, 1, 1024, 1, 0, "R4");
    step(1, -2048, 0, 1, 0, "R10");
    hold(2, 1, -2048, 1, 0, "R6");

    // dead time 3
    hold(2, 1, -2048, 1, 3, "R9");
    hold(2, 1, -2048, 0, 3, "R8");
    hold(6, 1, -2048, 1, 3, "R9");
    step(1, 200, 1, 1, 3, "R9");
    hold(6, 1, 200, 1, 3, "R9");
    hold(1, 1, 200, 0, 3, "R8");
    hold(2, 1, 200, 1, 3, "R9");
    hold(4, 1, 200, 1, 3, "R9");

    // dead time 1 and 15
    step(1, 1800, 0, 1, 1, "R9");
    hold(4, 1, 1800, 1, 1, "R9");
    step(1, -1800, 1, 1, 15, "R9");
    hold(20, 1, -1800, 1, 15, "R9");

    // disable and re-enable
    hold(3, 0, -1800, 1, 2, "R1");
    hold(5, 1, -1800, 0, 2, "R9");
    step(0, -1800, 1, 0, 2, "R1");
    hold(3, 1, -1800, 1, 0, "R6");

    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule